// File: doc/BRIEF.md
# Endpoint-0 Interrupt Flag Register

This block holds the interrupt flags that a USB device controller raises for its control endpoint and for changes of device state. The protocol core sends one-cycle event pulses: a setup transaction has completed, an OUT or IN handshake has taken place on endpoint 0 (with its type), or the device state has changed. Each pulse latches a sticky flag. The processor reads the flag vector and acknowledges flags by writing ones to them. The setup flag is the exception. It is acknowledged only when the processor selects the setup data for reading.

A separate enable mask gates the flags onto a single registered interrupt line. Two synchronous active-low resets are provided. The processor reset clears everything. The bus reset leaves the device-state-change flag set, so that software sees that a bus reset happened.

Top module: `usb_ep0_irq_flags`

## Requirements
- R1: While `cpu_rst_n` is low and `bus_rst_n` is high, a clock edge sets `flags` to 4'b0000, sets the enable mask to 0 and sets `irq` to 0.
- R2: While `bus_rst_n` is low, a clock edge sets `flags` to 4'b1000 (only bit 3 set) and `irq` to 0. This holds even when `cpu_rst_n` is also low.
- R3: A `setup_done` pulse sets bit 2 of `flags` at the next clock edge.
- R4: Writing a 1 to bit 2 through `wr_flags_en` leaves bit 2 unchanged. A `setup_sel` pulse clears bit 2 at the next edge. If `setup_done` arrives in the same cycle as `setup_sel`, bit 2 ends up set.
- R5: A handshake pulse on `ep0_out_hs` sets bit 1 and a pulse on `ep0_in_hs` sets bit 0, when the kind is ACK (2'b00) or STALL (2'b10). The reserved kind 2'b11 sets nothing.
- R6: A handshake of kind NAK (2'b01) sets its flag only while `nak_report_en` is 1. Otherwise it sets nothing.
- R7: With `wr_flags_en` high, each 1 in `wr_data` bits 3, 1 and 0 clears that flag, and each 0 leaves it unchanged. A set event on the same bit in the same cycle wins over the clear.
- R8: A `state_chg` pulse sets bit 3 of `flags` at the next clock edge.
- R9: `wr_mask_en` loads `wr_data` into the enable mask at the next edge. `irq` is a register that takes the OR over all bits of (flag AND mask), one edge after those values are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cpu_rst_n | input | 1 | Processor reset, synchronous, active low |
| bus_rst_n | input | 1 | USB bus reset, synchronous, active low |
| setup_done | input | 1 | Setup transaction completed pulse |
| ep0_out_hs | input | 1 | Endpoint-0 OUT handshake pulse |
| ep0_out_kind | input | 2 | OUT handshake kind: 00 ACK, 01 NAK, 10 STALL |
| ep0_in_hs | input | 1 | Endpoint-0 IN handshake pulse |
| ep0_in_kind | input | 2 | IN handshake kind, same encoding |
| nak_report_en | input | 1 | Allows NAK handshakes to raise flags |
| state_chg | input | 1 | Device-state-change pulse |
| setup_sel | input | 1 | Processor selects setup data; clears the setup flag |
| wr_flags_en | input | 1 | Write-one-to-clear strobe for the flags |
| wr_mask_en | input | 1 | Load strobe for the enable mask |
| wr_data | input | 4 | Processor write data |
| flags | output | 4 | Flag vector: 3 state change, 2 setup, 1 OUT, 0 IN |
| irq | output | 1 | Registered, masked interrupt request |

## Verification
Two functions can land on the same bit in the same cycle. The first is a core set event together with a processor acknowledge: `state_chg` with a write-one-clear of bit 3, or `setup_done` with `setup_sel`. The bench drives both stimuli in one cycle. It expects the flag to stay set, both in its directed checks and in its behavioural model, which it compares after every edge. The second is a mask load together with a flag change. Here the bench confirms that `irq` follows one edge after the new mask and flags become visible.

// File: rtl/usb_ep0_irq_pkg.sv
// Shared constants and types for the endpoint-0 interrupt flag register.
// Assumes a fixed four-flag layout that software decodes by bit position.
package usb_ep0_irq_pkg;
    localparam int FLAG_W    = 4;
    localparam int BIT_IN    = 0;
    localparam int BIT_OUT   = 1;
    localparam int BIT_SETUP = 2;
    localparam int BIT_DSC   = 3;
    localparam int KIND_W    = 2;

    // Flag value loaded by a bus reset: only the state-change flag is set.
    localparam logic [FLAG_W-1:0] BUS_RST_VAL = FLAG_W'(1) << BIT_DSC;

    typedef enum logic [KIND_W-1:0] {
        HS_ACK   = 2'b00,
        HS_NAK   = 2'b01,
        HS_STALL = 2'b10,
        HS_RSVD  = 2'b11
    } hs_kind_e;
endpackage

// File: rtl/ep0_hs_qual.sv
// Turns one handshake pulse and its kind into a flag-set request.
// Assumes the pulse lasts one cycle and the kind is valid with it.
module ep0_hs_qual
    import usb_ep0_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_ok,
    input  logic     hs_pulse,
    input  hs_kind_e hs_kind,
    input  logic     nak_report_en,
    output logic     set_req
);
    // Decode the handshake kind; NAK passes only when reporting is on.
    always_comb begin
        case (hs_kind)
            HS_ACK, HS_STALL: set_req = hs_pulse;
            HS_NAK:           set_req = hs_pulse & nak_report_en;
            default:          set_req = 1'b0;
        endcase
    end

    a_r6_nak_masked: assert property (@(posedge clk) disable iff (!rst_ok)
        (hs_pulse && hs_kind == HS_NAK && !nak_report_en) |-> !set_req);
    a_r5_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_ok)
        (hs_kind == HS_RSVD) |-> !set_req);
endmodule

// File: rtl/irq_flag_bank.sv
// Bank of sticky flags. Each flag sets on a request and clears on an acknowledge.
// The setup bit clears only on setup select; other bits clear on a write of 1.
// A set always wins over a clear in the same cycle. Resets are synchronous.
module irq_flag_bank #(
    parameter int                 W         = 4,
    parameter int                 SETUP_IDX = 2,
    parameter logic [W-1:0]       BUS_VAL   = '0
) (
    input  logic         clk,
    input  logic         cpu_rst_n,
    input  logic         bus_rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         w1c_en,
    input  logic [W-1:0] w1c_data,
    input  logic         setup_sel,
    output logic [W-1:0] flags_q
);
    logic rst_ok;
    assign rst_ok = cpu_rst_n & bus_rst_n;

    for (genvar b = 0; b < W; b++) begin : g_flag
        logic clr;
        logic flag_r;

        if (b == SETUP_IDX) begin : g_setup_clr
            // Setup flag acknowledge comes only from setup-data select.
            assign clr = setup_sel;
        end else begin : g_w1c_clr
            // Other flags are acknowledged by a write of 1.
            assign clr = w1c_en & w1c_data[b];
        end

        // Flag state: bus reset, then processor reset, then set, then clear.
        always_ff @(posedge clk) begin
            if (!bus_rst_n)      flag_r <= BUS_VAL[b];
            else if (!cpu_rst_n) flag_r <= 1'b0;
            else if (set_vec[b]) flag_r <= 1'b1;
            else if (clr)        flag_r <= 1'b0;
        end

        assign flags_q[b] = flag_r;

        a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_ok)
            set_vec[b] |=> flag_r);

        if (b == SETUP_IDX) begin : g_setup_chk
            a_r4_setup_holds: assert property (@(posedge clk) disable iff (!rst_ok)
                (flag_r && !setup_sel) |=> flag_r);
        end else begin : g_w1c_chk
            a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_ok)
                (w1c_en && w1c_data[b] && !set_vec[b]) |=> !flag_r);
        end
    end

    a_r2_bus_reset_value: assert property (@(posedge clk)
        !bus_rst_n |=> (flags_q == BUS_VAL));
endmodule

// File: rtl/irq_mask_out.sv
// Holds the enable mask and produces the registered interrupt line.
// The mask clears on processor reset only; the line clears on either reset.
module irq_mask_out #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         cpu_rst_n,
    input  logic         bus_rst_n,
    input  logic         wr_mask_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] flags,
    output logic         irq
);
    logic [W-1:0] mask_q;
    logic         irq_q;
    logic         rst_ok;

    assign rst_ok = cpu_rst_n & bus_rst_n;

    // Enable mask register, loaded by its own strobe.
    always_ff @(posedge clk) begin
        if (!cpu_rst_n)      mask_q <= '0;
        else if (wr_mask_en) mask_q <= wr_data;
    end

    // Registered OR of the enabled flags.
    always_ff @(posedge clk) begin
        if (!rst_ok) irq_q <= 1'b0;
        else         irq_q <= |(flags & mask_q);
    end

    assign irq = irq_q;

    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_ok)
        (|(flags & mask_q)) |=> irq);
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_ok)
        !(|(flags & mask_q)) |=> !irq);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !cpu_rst_n |=> (!irq && mask_q == '0));
endmodule

// File: rtl/usb_ep0_irq_flags.sv
// Top level: interrupt flags for endpoint 0 and device-state events.
// Assumes all event inputs are single-cycle pulses in the clk domain.
module usb_ep0_irq_flags
    import usb_ep0_irq_pkg::*;
(
    input  logic              clk,
    input  logic              cpu_rst_n,
    input  logic              bus_rst_n,
    input  logic              setup_done,
    input  logic              ep0_out_hs,
    input  logic [KIND_W-1:0] ep0_out_kind,
    input  logic              ep0_in_hs,
    input  logic [KIND_W-1:0] ep0_in_kind,
    input  logic              nak_report_en,
    input  logic              state_chg,
    input  logic              setup_sel,
    input  logic              wr_flags_en,
    input  logic              wr_mask_en,
    input  logic [FLAG_W-1:0] wr_data,
    output logic [FLAG_W-1:0] flags,
    output logic              irq
);
    logic              rst_ok;
    logic              out_set;
    logic              in_set;
    logic [FLAG_W-1:0] set_vec;

    assign rst_ok = cpu_rst_n & bus_rst_n;

    ep0_hs_qual u_out_qual (
        .clk           (clk),
        .rst_ok        (rst_ok),
        .hs_pulse      (ep0_out_hs),
        .hs_kind       (hs_kind_e'(ep0_out_kind)),
        .nak_report_en (nak_report_en),
        .set_req       (out_set)
    );

    ep0_hs_qual u_in_qual (
        .clk           (clk),
        .rst_ok        (rst_ok),
        .hs_pulse      (ep0_in_hs),
        .hs_kind       (hs_kind_e'(ep0_in_kind)),
        .nak_report_en (nak_report_en),
        .set_req       (in_set)
    );

    // Gather the set requests by flag position.
    always_comb begin
        set_vec            = '0;
        set_vec[BIT_IN]    = in_set;
        set_vec[BIT_OUT]   = out_set;
        set_vec[BIT_SETUP] = setup_done;
        set_vec[BIT_DSC]   = state_chg;
    end

    irq_flag_bank #(
        .W         (FLAG_W),
        .SETUP_IDX (BIT_SETUP),
        .BUS_VAL   (BUS_RST_VAL)
    ) u_bank (
        .clk       (clk),
        .cpu_rst_n (cpu_rst_n),
        .bus_rst_n (bus_rst_n),
        .set_vec   (set_vec),
        .w1c_en    (wr_flags_en),
        .w1c_data  (wr_data),
        .setup_sel (setup_sel),
        .flags_q   (flags)
    );

    irq_mask_out #(
        .W (FLAG_W)
    ) u_irq (
        .clk        (clk),
        .cpu_rst_n  (cpu_rst_n),
        .bus_rst_n  (bus_rst_n),
        .wr_mask_en (wr_mask_en),
        .wr_data    (wr_data),
        .flags      (flags),
        .irq        (irq)
    );

    a_r8_state_chg_sets: assert property (@(posedge clk) disable iff (!rst_ok)
        state_chg |=> flags[BIT_DSC]);
endmodule

// File: tb/usb_ep0_irq_flags_bench.sv
module usb_ep0_irq_flags_bench;
    logic       clk = 1'b0;
    logic       cpu_rst_n = 1'b0, bus_rst_n = 1'b1;
    logic       setup_done = 0, ep0_out_hs = 0, ep0_in_hs = 0;
    logic [1:0] ep0_out_kind = 0, ep0_in_kind = 0;
    logic       nak_report_en = 0, state_chg = 0, setup_sel = 0;
    logic       wr_flags_en = 0, wr_mask_en = 0;
    logic [3:0] wr_data = 0;
    logic [3:0] flags;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Behavioural reference state.
    logic [3:0] m_flags = 4'h0;
    logic [3:0] m_mask  = 4'h0;
    logic       m_irq   = 1'b0;

    always #5 clk = ~clk;

    usb_ep0_irq_flags u_usb_ep0_irq_flags (
        .clk(clk), .cpu_rst_n(cpu_rst_n), .bus_rst_n(bus_rst_n),
        .setup_done(setup_done), .ep0_out_hs(ep0_out_hs), .ep0_out_kind(ep0_out_kind),
        .ep0_in_hs(ep0_in_hs), .ep0_in_kind(ep0_in_kind), .nak_report_en(nak_report_en),
        .state_chg(state_chg), .setup_sel(setup_sel), .wr_flags_en(wr_flags_en),
        .wr_mask_en(wr_mask_en), .wr_data(wr_data), .flags(flags), .irq(irq)
    );

    function automatic bit hs_counts(input logic [1:0] k, input logic en);
        return (k == 2'b00) || (k == 2'b10) || (k == 2'b01 && en);
    endfunction

    // Reference model, advanced on every edge from the stable inputs.
    always @(posedge clk) begin
        logic [3:0] nf;
        logic       ni;
        nf = m_flags;
        ni = |(m_flags & m_mask);
        if (!bus_rst_n) nf = 4'b1000;
        else if (!cpu_rst_n) nf = 4'b0000;
        else begin
            if (wr_flags_en) begin
                for (int b = 0; b < 4; b++) if (b != 2 && wr_data[b]) nf[b] = 1'b0;
            end
            if (setup_sel) nf[2] = 1'b0;
            if (setup_done) nf[2] = 1'b1;
            if (state_chg) nf[3] = 1'b1;
            if (ep0_out_hs && hs_counts(ep0_out_kind, nak_report_en)) nf[1] = 1'b1;
            if (ep0_in_hs && hs_counts(ep0_in_kind, nak_report_en)) nf[0] = 1'b1;
        end
        if (!cpu_rst_n) m_mask = 4'h0;
        else if (wr_mask_en) m_mask = wr_data;
        m_irq   = (!cpu_rst_n || !bus_rst_n) ? 1'b0 : ni;
        m_flags = nf;
    end

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        setup_done = 0; ep0_out_hs = 0; ep0_in_hs = 0; state_chg = 0;
        setup_sel = 0; wr_flags_en = 0; wr_mask_en = 0; wr_data = 0;
        ep0_out_kind = 0; ep0_in_kind = 0;
    endtask

    // One clock: edge, then sample away from it and compare to the model.
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        chk("R2 model flags", flags, m_flags);
        chk("R9 model irq", {3'b0, irq}, {3'b0, m_irq});
    endtask

    task automatic pulse();
        cycle();
        idle_inputs();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: processor reset
        cycle(); cycle();
        chk("R1 flags", flags, 4'b0000);
        chk("R1 irq", {3'b0, irq}, 4'b0000);
        // R2: bus reset alone, then both together
        bus_rst_n = 0; cpu_rst_n = 1; cycle();
        chk("R2 bus reset", flags, 4'b1000);
        cpu_rst_n = 0; cycle();
        chk("R2 both resets", flags, 4'b1000);
        cpu_rst_n = 1; bus_rst_n = 1;
        wr_flags_en = 1; wr_data = 4'b1000; pulse();
        chk("R7 clear dsc", flags, 4'b0000);
        // R3 / R4: setup flag
        setup_done = 1; pulse();
        chk("R3 setup set", flags, 4'b0100);
        wr_flags_en = 1; wr_data = 4'b0100; pulse();
        chk("R4 w1c ignored", flags, 4'b0100);
        setup_sel = 1; pulse();
        chk("R4 setup_sel clears", flags, 4'b0000);
        setup_done = 1; setup_sel = 1; pulse();
        chk("R4 set beats select", flags, 4'b0100);
        setup_sel = 1; pulse();
        // R5: ACK and STALL, reserved kind
        ep0_out_hs = 1; ep0_out_kind = 2'b00; pulse();
        chk("R5 out ack", flags, 4'b0010);
        ep0_in_hs = 1; ep0_in_kind = 2'b10; pulse();
        chk("R5 in stall", flags, 4'b0011);
        wr_flags_en = 1; wr_data = 4'b0011; pulse();
        chk("R7 w1c both", flags, 4'b0000);
        ep0_in_hs = 1; ep0_in_kind = 2'b11; ep0_out_hs = 1; ep0_out_kind = 2'b11; pulse();
        chk("R5 reserved kind", flags, 4'b0000);
        // R6: NAK gating
        nak_report_en = 0; ep0_out_hs = 1; ep0_out_kind = 2'b01; pulse();
        chk("R6 nak blocked", flags, 4'b0000);
        nak_report_en = 1; ep0_in_hs = 1; ep0_in_kind = 2'b01; pulse();
        chk("R6 nak reported", flags, 4'b0001);
        nak_report_en = 0;
        // R7: write 0 leaves, set wins
        wr_flags_en = 1; wr_data = 4'b0000; pulse();
        chk("R7 write zero", flags, 4'b0001);
        wr_flags_en = 1; wr_data = 4'b0001; ep0_in_hs = 1; ep0_in_kind = 2'b00; pulse();
        chk("R7 set beats clear", flags, 4'b0001);
        wr_flags_en = 1; wr_data = 4'b0001; pulse();
        // R8: state change, and set vs clear on bit 3
        state_chg = 1; pulse();
        chk("R8 state change", flags, 4'b1000);
        state_chg = 1; wr_flags_en = 1; wr_data = 4'b1000; pulse();
        chk("R7 dsc set wins", flags, 4'b1000);
        // R9: mask and registered interrupt
        chk("R9 masked off", {3'b0, irq}, 4'b0000);
        wr_mask_en = 1; wr_data = 4'b1000; pulse();
        chk("R9 latency", {3'b0, irq}, 4'b0000);
        cycle();
        chk("R9 irq raised", {3'b0, irq}, 4'b0001);
        wr_flags_en = 1; wr_data = 4'b1000; pulse();
        chk("R9 irq one late", {3'b0, irq}, 4'b0001);
        cycle();
        chk("R9 irq dropped", {3'b0, irq}, 4'b0000);
        // R1: processor reset clears the mask
        ep0_out_hs = 1; ep0_out_kind = 2'b00; wr_mask_en = 1; wr_data = 4'b0010; pulse();
        cycle();
        chk("R9 out irq", {3'b0, irq}, 4'b0001);
        cpu_rst_n = 0; cycle(); cpu_rst_n = 1;
        chk("R1 reset flags", flags, 4'b0000);
        ep0_out_hs = 1; pulse(); cycle();
        chk("R1 mask cleared", {3'b0, irq}, 4'b0000);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule